// File: doc/BRIEF.md
# Interrupt Source Status Controller

This block keeps the interrupt state of a single interrupt source inside a peripheral. It also holds a small master interrupt control register that a group of such sources would share. The host changes the source's state by writing a command byte. The top three bits of that byte select an action on the pending, under-service and enable flags. A hardware event input marks the source as pending. The host reads back a status byte that also carries an error flag, which records an event lost because the source was already pending.

The master register supplies a global enable, a bit that blocks lower-priority sources and a reset bit. The global enable gates the interrupt request output. The lower-chain block bit, or a source that is under service, drives the daisy-chain enable output low. While the reset bit is 1, the source is held in its reset state.

All outputs are registers. The request and chain outputs are computed from the next state of the flags, so they change on the same clock edge as the status byte.

Top module: `isc_source_ctrl`

## Requirements
- R1: After synchronous reset (`rst`=1), `status_o`, `mst_rd_o` and `irq_o` are 0 and `chain_en_o` is 1.
- R2: On a command write, bits 7:5 of `host_cmd_data` select the action: 1 clears pending, under-service and error; 2 sets under-service; 3 clears under-service; 4 sets pending; 5 clears pending and error; 6 sets enable; 7 clears enable. The result is visible after the next rising edge.
- R3: `status_o` carries under-service at bit 7, enable at bit 6, pending at bit 5 and error at bit 4. Bits 3:0 read 0.
- R4: A cycle with `evt_i`=1 sets pending at the next edge.
- R5: An event that arrives while pending is already 1, with no clear-pending command (code 1 or 5) written in the same cycle, sets error. Error is cleared only by codes 1 and 5 or by a reset.
- R6: When an event and a command with code 1 or 5 occur in the same cycle, pending ends up 1 and error ends up 0.
- R7: `irq_o` is 1 exactly when master enable, enable and pending are all 1 and under-service is 0. It is updated on the same edge as the flags.
- R8: `chain_en_o` is 0 whenever under-service is 1 or the lower-chain block bit is 1, and 1 otherwise.
- R9: A master write stores master enable from bit 7, lower-chain block from bit 6, no-vector from bit 5 and the reset bit from bit 0. `mst_rd_o` returns these bits in the same positions, with bits 4:1 reading 0.
- R10: While the stored reset bit is 1, and on the edge that writes it as 1, all four flags are 0 and commands and events have no effect. Writing the bit back to 0 releases the source.
- R11: Command code 0 changes nothing, and bits 4:0 of a command byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cmd_wr | input | 1 | Command byte write strobe |
| host_cmd_data | input | 8 | Command byte; action code in bits 7:5 |
| evt_i | input | 1 | Hardware interrupt event, one cycle per event |
| mst_wr | input | 1 | Master control register write strobe |
| mst_data | input | 8 | Master control write data |
| status_o | output | 8 | Status byte (under-service, enable, pending, error) |
| mst_rd_o | output | 8 | Master control register read-back |
| irq_o | output | 1 | Interrupt request |
| chain_en_o | output | 1 | Daisy-chain enable to lower-priority sources |

## Verification
The assertions check invariants on every cycle. Error never stands without pending, and a request never appears without all of its enabling conditions. The chain output is low whenever service or the block bit demands it, and the flags stay zero while the reset bit is held. The assertions also check that an accepted event or clear-service command takes effect one edge later. Only the bench scenarios can show that each command code produces its exact status byte, that a same-cycle event wins over a clear-pending command, and that a source released from reset accepts commands again.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_CLR_BOTH = 3'd1,
    CMD_SET_SRV  = 3'd2,
    CMD_CLR_SRV  = 3'd3,
    CMD_SET_PEND = 3'd4,
    CMD_CLR_PEND = 3'd5,
    CMD_SET_EN   = 3'd6,
    CMD_CLR_EN   = 3'd7
  } isc_cmd_e;

  typedef struct packed {
    logic srv;
    logic en;
    logic pend;
    logic err;
  } isc_flags_t;

  localparam int unsigned FLAGS_W = $bits(isc_flags_t);
endpackage

// File: rtl/isc_master_ctrl.sv
module isc_master_ctrl #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              mie_n,
  output logic              dlc_n,
  output logic              hold_n,
  output logic              hold_q,
  output logic [BYTE_W-1:0] rd_o
);
  localparam int unsigned MIE_B = BYTE_W - 1;
  localparam int unsigned DLC_B = BYTE_W - 2;
  localparam int unsigned NV_B  = BYTE_W - 3;

  logic mie_q, dlc_q, nv_q;

  assign mie_n  = wr ? wdata[MIE_B] : mie_q;
  assign dlc_n  = wr ? wdata[DLC_B] : dlc_q;
  assign hold_n = wr ? wdata[0]     : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mie_q  <= 1'b0;
      dlc_q  <= 1'b0;
      nv_q   <= 1'b0;
      hold_q <= 1'b0;
    end else if (wr) begin
      mie_q  <= wdata[MIE_B];
      dlc_q  <= wdata[DLC_B];
      nv_q   <= wdata[NV_B];
      hold_q <= wdata[0];
    end
  end

  always_comb begin
    rd_o        = '0;
    rd_o[MIE_B] = mie_q;
    rd_o[DLC_B] = dlc_q;
    rd_o[NV_B]  = nv_q;
    rd_o[0]     = hold_q;
  end

  // R9
  mst_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (rd_o == {$past(wdata[BYTE_W-1:NV_B]), {(NV_B-1){1'b0}}, $past(wdata[0])}));
endmodule

// File: rtl/isc_flag_core.sv
module isc_flag_core
  import isc_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned CMD_LSB = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_n,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              evt,
  output isc_flags_t        flags_n,
  output isc_flags_t        flags_q
);
  localparam int unsigned CMD_W = BYTE_W - CMD_LSB;

  isc_cmd_e code;
  logic     clr_pend_cmd;

  assign code         = isc_cmd_e'(cmd_data[CMD_LSB +: CMD_W]);
  assign clr_pend_cmd = cmd_wr && (code == CMD_CLR_BOTH || code == CMD_CLR_PEND);

  always_comb begin
    flags_n = flags_q;
    if (cmd_wr) begin
      unique case (code)
        CMD_CLR_BOTH: begin flags_n.pend = 1'b0; flags_n.srv = 1'b0; flags_n.err = 1'b0; end
        CMD_SET_SRV:  flags_n.srv  = 1'b1;
        CMD_CLR_SRV:  flags_n.srv  = 1'b0;
        CMD_SET_PEND: flags_n.pend = 1'b1;
        CMD_CLR_PEND: begin flags_n.pend = 1'b0; flags_n.err = 1'b0; end
        CMD_SET_EN:   flags_n.en   = 1'b1;
        CMD_CLR_EN:   flags_n.en   = 1'b0;
        default:      ;
      endcase
    end
    if (evt) begin
      if (flags_q.pend && !clr_pend_cmd) flags_n.err = 1'b1;
      flags_n.pend = 1'b1;
    end
    if (hold_n) flags_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_n;
  end

  // R5
  err_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    flags_q.err |-> flags_q.pend);

  // R4
  evt_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && !hold_n) |=> flags_q.pend);

  // R2
  clr_srv_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && code == CMD_CLR_SRV && !hold_n) |=> !flags_q.srv);
endmodule

// File: rtl/isc_req_out.sv
module isc_req_out
  import isc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  isc_flags_t flags_n,
  input  logic       mie_n,
  input  logic       dlc_n,
  output logic       irq_o,
  output logic       chain_en_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b0;
      chain_en_o <= 1'b1;
    end else begin
      irq_o      <= mie_n && flags_n.en && flags_n.pend && !flags_n.srv;
      chain_en_o <= !(flags_n.srv || dlc_n);
    end
  end
endmodule

// File: rtl/isc_source_ctrl.sv
module isc_source_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned CMD_LSB = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cmd_wr,
  input  logic [BYTE_W-1:0] host_cmd_data,
  input  logic              evt_i,
  input  logic              mst_wr,
  input  logic [BYTE_W-1:0] mst_data,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] mst_rd_o,
  output logic              irq_o,
  output logic              chain_en_o
);
  localparam int unsigned PAD_W = BYTE_W - FLAGS_W;

  logic       mie_n, dlc_n, hold_n, hold_q;
  isc_flags_t flags_n, flags_q;

  isc_master_ctrl #(.BYTE_W(BYTE_W)) u_master (
    .clk(clk), .rst(rst), .wr(mst_wr), .wdata(mst_data),
    .mie_n(mie_n), .dlc_n(dlc_n), .hold_n(hold_n), .hold_q(hold_q),
    .rd_o(mst_rd_o)
  );

  isc_flag_core #(.BYTE_W(BYTE_W), .CMD_LSB(CMD_LSB)) u_flags (
    .clk(clk), .rst(rst), .hold_n(hold_n), .cmd_wr(host_cmd_wr),
    .cmd_data(host_cmd_data), .evt(evt_i),
    .flags_n(flags_n), .flags_q(flags_q)
  );

  isc_req_out u_req (
    .clk(clk), .rst(rst), .flags_n(flags_n), .mie_n(mie_n), .dlc_n(dlc_n),
    .irq_o(irq_o), .chain_en_o(chain_en_o)
  );

  assign status_o = {flags_q, {PAD_W{1'b0}}};

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (status_o[BYTE_W-2] && status_o[BYTE_W-3] && !status_o[BYTE_W-1]
               && mst_rd_o[BYTE_W-1]));

  // R8
  chain_block_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o[BYTE_W-1] || mst_rd_o[BYTE_W-2]) |-> !chain_en_o);

  // R10
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> (status_o == '0 && !irq_o));
endmodule

// File: tb/test_isc_source_ctrl.sv
module test_isc_source_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic       clk = 1'b0;
  logic       rst;
  logic       host_cmd_wr;
  logic [7:0] host_cmd_data;
  logic       evt_i;
  logic       mst_wr;
  logic [7:0] mst_data;
  logic [7:0] status_o, mst_rd_o;
  logic       irq_o, chain_en_o;

  int n_checks = 0;
  int n_fail   = 0;

  // {wr, cmd[7:0], evt, exp_status[7:0], exp_irq}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 8'hC0, 1'b0, 8'h40, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'h60, 1'b1},
    {1'b0, 8'h00, 1'b1, 8'h70, 1'b1},
    {1'b1, 8'h40, 1'b0, 8'hF0, 1'b0},
    {1'b1, 8'h60, 1'b0, 8'h70, 1'b1},
    {1'b1, 8'hA0, 1'b0, 8'h40, 1'b0},
    {1'b1, 8'h80, 1'b0, 8'h60, 1'b1},
    {1'b1, 8'h1F, 1'b0, 8'h60, 1'b1},
    {1'b1, 8'hA0, 1'b1, 8'h60, 1'b1},
    {1'b1, 8'h40, 1'b0, 8'hE0, 1'b0},
    {1'b1, 8'h20, 1'b0, 8'h40, 1'b0},
    {1'b1, 8'hE0, 1'b0, 8'h00, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'h20, 1'b0},
    {1'b1, 8'hC0, 1'b0, 8'h60, 1'b1}
  };

  isc_source_ctrl i_isc_source_ctrl (
    .clk(clk), .rst(rst), .host_cmd_wr(host_cmd_wr), .host_cmd_data(host_cmd_data),
    .evt_i(evt_i), .mst_wr(mst_wr), .mst_data(mst_data),
    .status_o(status_o), .mst_rd_o(mst_rd_o), .irq_o(irq_o), .chain_en_o(chain_en_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive for one edge, then sample at the following falling edge
  task automatic step(input logic cw, input logic [7:0] cd, input logic ev,
                      input logic mw, input logic [7:0] md);
    host_cmd_wr = cw; host_cmd_data = cd; evt_i = ev; mst_wr = mw; mst_data = md;
    @(negedge clk);
    host_cmd_wr = 1'b0; evt_i = 1'b0; mst_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; host_cmd_wr = 1'b0; host_cmd_data = '0; evt_i = 1'b0;
    mst_wr = 1'b0; mst_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 status", status_o, 8'h00);
    check("R1 master", mst_rd_o, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    check("R1 chain", {7'b0, chain_en_o}, 8'h01);

    // R9 master enable set, bits 4:1 read zero
    step(0, 0, 0, 1, 8'h9E);
    check("R9 master readback", mst_rd_o, 8'h80);

    // R2 R3 R4 R5 R6 R7 R11 command table
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][18], VEC[i][17:10], VEC[i][9], 0, 0);
      check($sformatf("R2/R3 vec%0d status", i), status_o, VEC[i][8:1]);
      check($sformatf("R7 vec%0d irq", i), {7'b0, irq_o}, {7'b0, VEC[i][0]});
      check($sformatf("R8 vec%0d chain", i), {7'b0, chain_en_o}, {7'b0, ~VEC[i][8]});
    end

    // R8 lower-chain block
    step(0, 0, 0, 1, 8'hE0);
    check("R9 master E0", mst_rd_o, 8'hE0);
    check("R8 chain blocked", {7'b0, chain_en_o}, 8'h00);
    check("R7 irq kept", {7'b0, irq_o}, 8'h01);

    // R7 master enable off
    step(0, 0, 0, 1, 8'h00);
    check("R7 irq masked", {7'b0, irq_o}, 8'h00);
    check("R8 chain open", {7'b0, chain_en_o}, 8'h01);

    // R10 soft reset hold
    step(0, 0, 0, 1, 8'h81);
    check("R10 flags cleared", status_o, 8'h00);
    check("R10 master", mst_rd_o, 8'h81);
    step(1, 8'hC0, 1, 0, 0);
    check("R10 ignored", status_o, 8'h00);
    check("R10 no irq", {7'b0, irq_o}, 8'h00);
    step(0, 0, 0, 1, 8'h80);
    check("R10 release", status_o, 8'h00);
    step(1, 8'hC0, 0, 0, 0);
    check("R10 after release", status_o, 8'h40);
    step(0, 0, 1, 0, 0);
    check("R4 pend again", status_o, 8'h60);
    check("R7 irq again", {7'b0, irq_o}, 8'h01);
    // R11 code 0 with ones in low bits
    step(1, 8'h1F, 0, 0, 0);
    check("R11 nop", status_o, 8'h60);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule